// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block turns bus addresses into seven active-low select strobes. Each strobe covers one 256-byte window. The seven windows sit one after another above a programmable base address. The base is aligned to a 2 KB boundary, so window n starts at base + n*256 for n = 0 to 6. A configuration input places the whole block in either I/O space or memory space. A select fires only for bus cycles of that type.

The address is sampled on the address-latch strobe. The matching select goes low on that clock edge and stays low until the bus cycle ends. Address bits 1 and 2 are captured at the same moment. When the expansion bit is clear, select pins 5 and 6 stop acting as strobes and drive these two latched bits instead. While bus hold is asserted, every strobe is forced high. The latched address bits keep their value through hold. All pins come from flip-flops on the system clock.

Top module: `periph_select_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, all seven pins of `sel_n` are high and both latched address bits are 0.
- R2: On a clock edge where `ale` is 1 and `hold` is 0, the pin for window n goes low from that edge on, with every other strobe high, when all of these hold: `addr[19:11]` equals `cfg_base`, `addr[10:8]` equals n (n from 0 to 6), and `cyc_io` equals `cfg_io_space`. Here `cyc_io` = 1 means an I/O cycle.
- R3: Any offset inside a window selects it. An address with `addr[10:8]` = 7, or with `addr[19:11]` different from `cfg_base`, asserts no strobe.
- R4: When `cyc_io` differs from `cfg_io_space`, an address that would otherwise match asserts no strobe.
- R5: An asserted strobe stays low over the cycles with `ale` = 0. It returns high on the first clock edge where `cyc_done` is 1 and `ale` is 0.
- R6: On any clock edge where `hold` is 1, every strobe goes high, and an `ale` pulse at that edge is ignored. After hold ends, strobes stay high until the next `ale`.
- R7: When `cfg_expand` is 0, `sel_n[5]` drives the `addr[1]` value and `sel_n[6]` drives the `addr[2]` value, both captured on the last `ale` accepted outside hold. Accesses to windows 5 and 6 then produce no strobe on those pins.
- R8: The latched address bits keep their value through bus hold and between `ale` pulses.
- R9: When `cfg_expand` is 1, `sel_n[5]` and `sel_n[6]` act as strobes for windows 5 and 6, in the same way as the other windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Bus address |
| ale | input | 1 | Address-latch strobe; the address is sampled when it is 1 |
| cyc_io | input | 1 | Cycle type: 1 for I/O, 0 for memory |
| cyc_done | input | 1 | End of the current bus cycle |
| hold | input | 1 | Bus hold indication |
| cfg_base | input | 9 | Base address bits 19 to 11 (2 KB aligned) |
| cfg_io_space | input | 1 | 1 places the block in I/O space, 0 in memory space |
| cfg_expand | input | 1 | 1 makes pins 5 and 6 strobes; 0 makes them latched address bits |
| sel_n | output | 7 | Active-low select pins; bits 5 and 6 may carry latched address bits |

## Verification
A wrong window index or base compare shows as a low pin on the wrong bit of `sel_n`, or as a missing strobe. This appears on the clock edge that samples `ale`. A stuck active-window register shows up later: the strobe fails to clear on the edge after `cyc_done`, or it survives into a hold cycle. A latched bit that updates during hold, or outside an `ale` pulse, shows on pins 5 or 6 at the first edge of that cycle when the expansion bit is clear. The reference model is compared against `sel_n` on every clock, so each of these faults shows up within one cycle.

// File: rtl/psel_pkg.sv
package psel_pkg;
    localparam int NSEL   = 7;
    localparam int LATW   = 2;
    localparam int PIN_A1 = 5;
    localparam int PIN_A2 = 6;

    typedef struct packed {
        logic [NSEL-1:0] active;
        logic [LATW-1:0] a_lat;
        logic [NSEL-1:0] pins;
    } psel_state_t;
endpackage

// File: rtl/psel_region_match.sv
module psel_region_match #(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 8,
    parameter int ALIGN_SHIFT  = 11,
    parameter int NSEL         = 7
) (
    input  logic [ADDR_W-1:REGION_SHIFT]   addr_hi,
    input  logic [ADDR_W-ALIGN_SHIFT-1:0]  base,
    input  logic                           io_cyc,
    input  logic                           io_cfg,
    output logic [NSEL-1:0]                hit
);
    localparam int IDX_W = ALIGN_SHIFT - REGION_SHIFT;

    logic             blk_hit;
    logic [IDX_W-1:0] idx;

    assign blk_hit = (addr_hi[ADDR_W-1:ALIGN_SHIFT] == base) && (io_cyc == io_cfg);
    assign idx     = addr_hi[ALIGN_SHIFT-1:REGION_SHIFT];

    for (genvar g = 0; g < NSEL; g++) begin : g_win
        assign hit[g] = blk_hit && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/psel_pin_mux.sv
module psel_pin_mux #(
    parameter int NSEL   = 7,
    parameter int PIN_A1 = 5,
    parameter int PIN_A2 = 6
) (
    input  logic [NSEL-1:0] active,
    input  logic [1:0]      a_lat,
    input  logic            expand,
    output logic [NSEL-1:0] pins
);
    for (genvar g = 0; g < NSEL; g++) begin : g_pin
        if (g == PIN_A1) begin : g_a1
            assign pins[g] = expand ? ~active[g] : a_lat[0];
        end else if (g == PIN_A2) begin : g_a2
            assign pins[g] = expand ? ~active[g] : a_lat[1];
        end else begin : g_cs
            assign pins[g] = ~active[g];
        end
    end
endmodule

// File: rtl/periph_select_unit.sv
module periph_select_unit
    import psel_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 8,
    parameter int ALIGN_SHIFT  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          ale,
    input  logic                          cyc_io,
    input  logic                          cyc_done,
    input  logic                          hold,
    input  logic [ADDR_W-ALIGN_SHIFT-1:0] cfg_base,
    input  logic                          cfg_io_space,
    input  logic                          cfg_expand,
    output logic [NSEL-1:0]               sel_n
);
    psel_state_t     st_d, st_q;
    logic [NSEL-1:0] hit;
    logic [NSEL-1:0] pins_d;
    logic            unused_addr_bits;

    assign unused_addr_bits = ^{addr[REGION_SHIFT-1:3], addr[0]};

    psel_region_match #(
        .ADDR_W(ADDR_W), .REGION_SHIFT(REGION_SHIFT),
        .ALIGN_SHIFT(ALIGN_SHIFT), .NSEL(NSEL)
    ) u_match (
        .addr_hi (addr[ADDR_W-1:REGION_SHIFT]),
        .base    (cfg_base),
        .io_cyc  (cyc_io),
        .io_cfg  (cfg_io_space),
        .hit     (hit)
    );

    psel_pin_mux #(.NSEL(NSEL), .PIN_A1(PIN_A1), .PIN_A2(PIN_A2)) u_mux (
        .active (st_d.active),
        .a_lat  (st_d.a_lat),
        .expand (cfg_expand),
        .pins   (pins_d)
    );

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.active = '0;
        end else if (ale) begin
            st_d.active = hit;
            st_d.a_lat  = addr[2:1];
        end else if (cyc_done) begin
            st_d.active = '0;
        end
        st_d.pins = pins_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= '0;
            st_q.a_lat  <= '0;
            st_q.pins   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_n = st_q.pins;

    // R2: at most one window is live at a time
    p_single_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.active));

    // R4: wrong cycle type never opens a window
    p_space_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !hold && (cyc_io != cfg_io_space)) |=> (st_q.active == '0));

    // R5: end of cycle closes the window
    p_cycle_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !ale) |=> (st_q.active == '0));

    // R6: hold forces every strobe inactive
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.active == '0));

    // R8: latched bits frozen during hold
    p_hold_keeps_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.a_lat));

    // R8: latched bits change only on an accepted ale
    p_no_ale_keeps_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(st_q.a_lat));
endmodule

// File: tb/periph_select_unit_test.sv
module periph_select_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        ale = 1'b0;
    logic        cyc_io = 1'b0;
    logic        cyc_done = 1'b0;
    logic        hold = 1'b0;
    logic [8:0]  cfg_base = '0;
    logic        cfg_io_space = 1'b1;
    logic        cfg_expand = 1'b1;
    logic [6:0]  sel_n;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    int       m_win;
    bit       m_a1, m_a2;
    bit [6:0] m_pins;

    always #10 clk = ~clk;

    periph_select_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ale(ale), .cyc_io(cyc_io),
        .cyc_done(cyc_done), .hold(hold), .cfg_base(cfg_base),
        .cfg_io_space(cfg_io_space), .cfg_expand(cfg_expand), .sel_n(sel_n)
    );

    // Behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_win = -1; m_a1 = 0; m_a2 = 0; m_pins = 7'h7f;
        end else begin
            if (hold) m_win = -1;
            else if (ale) begin
                int idx;
                idx = (addr >> 8) % 8;
                m_a1 = addr[1]; m_a2 = addr[2];
                if ((addr >> 11) == cfg_base && cyc_io == cfg_io_space && idx < 7)
                    m_win = idx;
                else
                    m_win = -1;
            end else if (cyc_done) m_win = -1;
            m_pins = 7'h7f;
            if (m_win >= 0) m_pins[m_win] = 1'b0;
            if (!cfg_expand) begin
                m_pins[5] = m_a1;
                m_pins[6] = m_a2;
            end
        end
    end

    task automatic check(input logic [6:0] got, input logic [6:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sel_n=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Every-cycle comparison, sampled mid-cycle
    always @(negedge clk) if (rst_n) check(sel_n, m_pins, cur_req);

    task automatic bus_cycle(input logic [19:0] a, input logic io, input int gap);
        @(negedge clk); addr = a; cyc_io = io; ale = 1'b1;
        @(negedge clk); ale = 1'b0;
        for (int i = 0; i < gap; i++) @(negedge clk);
        cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #200000000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        cfg_base = 9'h012;
        repeat (3) @(negedge clk);
        check(sel_n, 7'h7f, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(sel_n, 7'h7f, "R1");

        cur_req = "R2";
        for (int n = 0; n < 7; n++) begin
            bus_cycle({cfg_base, 11'h0} | 20'(n << 8) | 20'h0, 1'b1, 1);
        end
        cur_req = "R9";
        bus_cycle({cfg_base, 11'h5ff} & 20'hfffff, 1'b1, 2);
        bus_cycle({cfg_base, 11'h6a3}, 1'b1, 0);
        cur_req = "R3";
        bus_cycle({cfg_base, 11'h3ff}, 1'b1, 1);
        bus_cycle({cfg_base, 11'h7c0}, 1'b1, 1);
        bus_cycle({9'h013, 11'h100}, 1'b1, 1);
        cur_req = "R4";
        bus_cycle({cfg_base, 11'h200}, 1'b0, 1);
        cfg_io_space = 1'b0;
        bus_cycle({cfg_base, 11'h200}, 1'b1, 1);
        bus_cycle({cfg_base, 11'h200}, 1'b0, 1);
        cur_req = "R5";
        bus_cycle({cfg_base, 11'h410}, 1'b0, 5);

        cur_req = "R6";
        @(negedge clk); addr = {cfg_base, 11'h100}; cyc_io = 1'b0; ale = 1'b1;
        @(negedge clk); ale = 1'b0; hold = 1'b1;
        @(negedge clk);
        check(sel_n, 7'h7f, "R6");
        addr = {cfg_base, 11'h300}; ale = 1'b1;
        @(negedge clk); ale = 1'b0; hold = 1'b0;
        @(negedge clk);
        check(sel_n, 7'h7f, "R6");

        cur_req = "R7";
        cfg_expand = 1'b0;
        bus_cycle({cfg_base, 11'h002}, 1'b0, 1);
        check(sel_n, 7'b0111111, "R7");
        bus_cycle({cfg_base, 11'h504}, 1'b0, 1);
        check(sel_n, 7'b1011111, "R7");
        bus_cycle({9'h1ff, 11'h606}, 1'b1, 1);
        check(sel_n, 7'b1111111, "R7");

        cur_req = "R8";
        @(negedge clk); hold = 1'b1; addr = 20'h00000; ale = 1'b1;
        @(negedge clk); ale = 1'b0;
        @(negedge clk);
        check(sel_n, 7'b1111111, "R8");
        hold = 1'b0;
        @(negedge clk); addr = 20'h00002;
        repeat (3) @(negedge clk);
        check(sel_n, 7'b1111111, "R8");
        bus_cycle({cfg_base, 11'h200}, 1'b0, 2);
        check(sel_n, 7'b0011111, "R8");

        cur_req = "R9";
        cfg_expand = 1'b1;
        bus_cycle({cfg_base, 11'h600}, 1'b0, 1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule